// File: doc/BRIEF.md
# Condition-driven vector length truncation sequencer

This block walks the elements of a vector operation in ascending order, starting at element 0, and decides for each one whether its result may be committed. A run begins with a `start` pulse that loads the original vector length. After that the execution side presents one element per cycle: its index and the 4-bit condition field produced for it. The sequencer picks one bit of that field and compares it against an invert control. When the bit equals the invert control, the test fails. The vector then ends at that element, and every element after it is cancelled.

An inclusive control decides whether the failing element still counts. When it is clear, the new length is the failing index and that element is not written. When it is set, the failing element is written and included in the new length. A compare-only control forces the test onto the equality bit, whatever the selector says. A run that never fails keeps its original length. A failure at element 0 with the inclusive control clear gives a length of zero, which is a legal result. The new length depends only on the outcome of the tests.

Top module: `ffirst_seq`

## Requirements
- R1: An element is accepted only while a run is active and its index equals the next expected index, starting at 0 and rising by one. Any other presented element is ignored: it causes no write, does not advance the run and does not end the run.
- R2: The condition field bits are lt=cond[0], gt=cond[1], eq=cond[2] and so=cond[3]. `sel` values 0, 1, 2 and 3 pick lt, gt, eq and so in that order. The test fails when the picked bit equals `inv`.
- R3: On a failing element with `incl`=0, the cycle after acceptance shows `done`=1 with `new_vl` equal to the failing index, and `wr_en`=0.
- R4: On a failing element with `incl`=1, the cycle after acceptance shows `done`=1 with `new_vl` equal to the failing index plus one, and `wr_en`=1 with `wr_idx` equal to the failing index.
- R5: After a run ends, no element is written until the next `start`, even if elements with the following index are presented.
- R6: A failure at element 0 with `incl`=0 gives `new_vl`=0.
- R7: With `cmp_only`=1, the test uses the eq bit whatever the value of `sel`.
- R8: If no element fails, `done` pulses one cycle after element VL-1 is accepted, and `new_vl` equals the original VL.
- R9: A `start` with `vl_in`=0 gives `done`=1 and `new_vl`=0 in the next cycle, and no write takes place.
- R10: For each element that is accepted and passes, `wr_en`=1 and `wr_idx`=index in the cycle after acceptance. After reset, `wr_en`, `done` and `new_vl` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run with length `vl_in` |
| vl_in | input | IDXW+1 | Original vector length |
| sel | input | 2 | Condition bit selector |
| inv | input | 1 | Value of the picked bit that fails the test |
| incl | input | 1 | Count and write the failing element |
| cmp_only | input | 1 | Force the test onto the eq bit |
| elem_valid | input | 1 | An element is presented this cycle |
| elem_idx | input | IDXW | Index of the presented element |
| cond | input | 4 | Condition field of the presented element |
| wr_en | output | 1 | Commit the result of element `wr_idx` |
| wr_idx | output | IDXW | Index being committed |
| done | output | 1 | One-cycle pulse when the run ends |
| new_vl | output | IDXW+1 | Resulting vector length, held until the next run ends |

## Verification
The hardest situations to reach are the cycles right after a run ends, when the execution side keeps offering elements that must stay cancelled. Each scenario task therefore ends by offering the element that would have come next and checks that no write appears. Out-of-order indices are injected in the middle of a passing run. The run must then ignore them and resume at the right index. Failures are placed at element 0, in the middle and at the last element, with both settings of the inclusive control.

// File: rtl/ffirst_seq.sv
module ffirst_seq #(
  parameter int IDXW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [IDXW:0]   vl_in,
  input  logic [1:0]      sel,
  input  logic            inv,
  input  logic            incl,
  input  logic            cmp_only,
  input  logic            elem_valid,
  input  logic [IDXW-1:0] elem_idx,
  input  logic [3:0]      cond,
  output logic            wr_en,
  output logic [IDXW-1:0] wr_idx,
  output logic            done,
  output logic [IDXW:0]   new_vl
);
  localparam int EQ_BIT = 2;

  logic          busy;
  logic [IDXW:0] cnt;
  logic [IDXW:0] vl;

  wire          take    = busy && elem_valid && ({1'b0, elem_idx} == cnt);
  wire          tbit    = cmp_only ? cond[EQ_BIT] : cond[sel];
  wire          fail    = (tbit == inv);
  wire [IDXW:0] cnt_nxt = cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      vl     <= '0;
      new_vl <= '0;
      done   <= 1'b0;
      wr_en  <= 1'b0;
      wr_idx <= '0;
    end else begin
      done  <= 1'b0;
      wr_en <= 1'b0;
      if (start) begin
        vl   <= vl_in;
        cnt  <= '0;
        busy <= (vl_in != '0);
        if (vl_in == '0) begin
          done   <= 1'b1;
          new_vl <= '0;
        end
      end else if (take) begin
        wr_idx <= cnt[IDXW-1:0];
        if (fail) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          wr_en  <= incl;
          new_vl <= incl ? cnt_nxt : cnt;
        end else begin
          wr_en <= 1'b1;
          cnt   <= cnt_nxt;
          if (cnt_nxt == vl) begin
            busy   <= 1'b0;
            done   <= 1'b1;
            new_vl <= vl;
          end
        end
      end
    end
  end

  assert_no_write_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !wr_en);

  assert_write_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ({1'b0, wr_idx} < vl));

  assert_trunc_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (new_vl <= vl));

  assert_zero_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && vl_in == '0) |=> (done && new_vl == '0 && !wr_en));

  assert_incl_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !start && fail && incl) |=> (wr_en && done && new_vl == {1'b0, wr_idx} + 1'b1));
endmodule

// File: tb/sim_ffirst_seq.sv
module sim_ffirst_seq;
  localparam int IDXW = 6;

  logic clk = 0, rst_n = 0;
  logic start = 0, inv = 0, incl = 0, cmp_only = 0, elem_valid = 0;
  logic [IDXW:0] vl_in = '0;
  logic [1:0] sel = '0;
  logic [IDXW-1:0] elem_idx = '0;
  logic [3:0] cond = '0;
  logic wr_en, done;
  logic [IDXW-1:0] wr_idx;
  logic [IDXW:0] new_vl;

  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  ffirst_seq #(.IDXW(IDXW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .vl_in(vl_in), .sel(sel),
    .inv(inv), .incl(incl), .cmp_only(cmp_only), .elem_valid(elem_valid),
    .elem_idx(elem_idx), .cond(cond), .wr_en(wr_en), .wr_idx(wr_idx),
    .done(done), .new_vl(new_vl));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic begin_run(input int vl, input int s, input bit iv, input bit ic, input bit co);
    @(negedge clk);
    start = 1; vl_in = vl[IDXW:0]; sel = s[1:0]; inv = iv; incl = ic; cmp_only = co;
    @(negedge clk);
    start = 0;
  endtask

  // Runs a vector; conds holds 4 bits per element; skew injects a wrong index before element skew
  task automatic run(input string tag, input int vl, input int s, input bit iv, input bit ic,
                     input bit co, input logic [63:0] conds, input int skew);
    int ended = 0;
    int exp_vl = vl;
    begin_run(vl, s, iv, ic, co);
    for (int i = 0; i < vl && !ended; i++) begin
      logic [3:0] c;
      bit b, f, ew, ed;
      if (i == skew) begin
        elem_valid = 1; elem_idx = IDXW'(i + 1); cond = 4'hF;
        @(negedge clk);
        chk(!wr_en && !done, {tag, " R1 skew ignored"}, wr_en, 0);
      end
      c = conds[i*4 +: 4];
      b = co ? c[2] : c[s];
      f = (b == iv);
      elem_valid = 1; elem_idx = IDXW'(i); cond = c;
      @(negedge clk);
      ew = !f || ic;
      ed = f || (i == vl - 1);
      if (f) exp_vl = ic ? i + 1 : i;
      chk(wr_en == ew, {tag, f ? (ic ? " R4 wr_en" : " R3 wr_en") : " R10 wr_en"}, wr_en, ew);
      if (ew) chk(wr_idx == IDXW'(i), {tag, " R10 wr_idx"}, wr_idx, i);
      chk(done == ed, {tag, f ? " R3 done" : " R8 done"}, done, ed);
      if (ed) begin
        chk(new_vl == (IDXW+1)'(exp_vl), {tag, f ? (ic ? " R4 new_vl" : " R3 new_vl") : " R8 new_vl"},
            new_vl, exp_vl);
        ended = 1;
      end
    end
    elem_valid = 1; elem_idx = IDXW'(exp_vl); cond = 4'hF;
    @(negedge clk);
    chk(!wr_en && !done, {tag, " R5 no write after end"}, wr_en, 0);
    elem_valid = 1; elem_idx = IDXW'(vl < 63 ? vl : 0); cond = 4'h0;
    @(negedge clk);
    chk(!wr_en, {tag, " R5 cancelled"}, wr_en, 0);
    chk(new_vl == (IDXW+1)'(exp_vl), {tag, " R5 new_vl held"}, new_vl, exp_vl);
    elem_valid = 0;
  endtask

  task automatic zero_len();
    begin_run(0, 0, 0, 0, 0);
    chk(done == 1'b1, "R9 done", done, 1);
    chk(new_vl == '0, "R9 new_vl", new_vl, 0);
    chk(!wr_en, "R9 no write", wr_en, 0);
    elem_valid = 1; elem_idx = '0; cond = 4'hF;
    @(negedge clk);
    chk(!wr_en && !done, "R9 element ignored", wr_en, 0);
    elem_valid = 0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!wr_en && !done && new_vl == '0, "R10 reset state", {wr_en, done}, 0);
    rst_n = 1;
    // no failure, eq bit set everywhere, inv=0
    run("pass_all", 8, 2, 0, 0, 0, 64'h4444_4444, 3);
    // R2: gt bit selected, fails at element 3 (gt clear), exclusive
    run("R2 gt mid", 6, 1, 0, 0, 0, 64'h0022_0222, 99);
    // R4 inclusive, lt selected, inv=1 fails when lt set at element 4
    run("R4 incl", 7, 0, 1, 1, 0, 64'h0001_0000, 2);
    // R6: element 0 fails exclusive
    run("R6 first", 5, 3, 0, 0, 0, 64'h0000_0000, 99);
    // element 0 fails inclusive
    run("first incl", 5, 3, 1, 1, 0, 64'h0000_0008, 99);
    // R7: sel points at so but cmp_only uses eq; eq clear at element 2, inv=0
    run("R7 cmp", 6, 3, 0, 1, 1, 64'h0044_4844, 99);
    // R2 so bit selected with no failure
    run("R2 so", 4, 3, 0, 0, 0, 64'h0000_8888, 99);
    // failure on last element, exclusive
    run("last", 4, 2, 1, 0, 0, 64'h0000_4000, 99);
    zero_len();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule